// File: doc/BRIEF.md
# Programmable Per-Line Edge Detector Bank

This block watches a wide bank of single-bit signals, 256 by default, and raises a one-cycle event for every line on which a chosen transition has just occurred. Each line has its own 2-bit detection code. The code picks rising, falling or both-edge detection, and one code value disables the line. Each line also has a 1-bit mask that removes it from the results. The outputs are the per-line event vector and a single flag that is high whenever any bit of that vector is high.

Software, or a configuration sequencer, programs the block through a plain 32-bit register port. A write is one cycle with `cfg_we` high. A read is combinational on `cfg_addr`. Detection codes are packed sixteen lines per word. Mask bits are packed thirty-two lines per word. One further register holds the global enable.

Every input is sampled once. An edge is found by comparing each sample with the previous sample of the same line. While the block is disabled, and during reset, the previous-sample register follows the inputs. This means enabling the block never reports a change that happened before the enable.

Top module: `edge_bank_top`

## Requirements
- R1: After a synchronous active-low reset, `evt_vec` and `evt_any` are 0, every configuration register reads 0, and detection is disabled.
- R2: Address 0..15 reads and writes the detection-code words. Address 16..23 reads and writes the mask words. Address 24 holds the enable in bit 0 and reads 0 in bits 31:1. Reads of any other address return 0, and writes to any other address change nothing.
- R3: A line with code 0 reports an event only on a 0-to-1 change of its input.
- R4: A line with code 1 reports an event only on a 1-to-0 change of its input.
- R5: A line with code 2 reports an event on any change of its input.
- R6: A line with code 3 never reports an event.
- R7: The code for line n occupies bits 2*(n%16)+1 down to 2*(n%16) of code word n/16. The mask bit for line n is bit n%32 of mask word n/32, which sits at address 16 + n/32.
- R8: A line whose mask bit is 1 never appears in `evt_vec` and does not contribute to `evt_any`.
- R9: `evt_any` is 1 exactly when at least one bit of `evt_vec` is 1, in the same cycle.
- R10: An input change captured at clock edge k appears on the outputs after edge k+1 and lasts exactly one cycle.
- R11: While the enable is 0, no events are reported. The outputs are 0 from the cycle after the enable is seen low.
- R12: Input changes made while the block is disabled, or during reset, produce no event after the block is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_in | input | NUM_LINES | Monitored single-bit lines |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register word address |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data (combinational on address) |
| evt_vec | output | NUM_LINES | Per-line event pulses |
| evt_any | output | 1 | High when any line reports an event |

## Verification
A table of single-line cases drives each detection code through both a rising and a falling change. This separates the four codes from each other, and a steady input shows that no event comes without a change. The cases sit on lines at word boundaries (15, 16, 31, 32, 240, 255), so a packing or shift error lands on the wrong line and is caught. A multi-line pattern with a partial mask, and then a full mask, tells apart per-line gating from gating of the summary flag. Cycle-exact probes before, at and after the event cycle pin down the latency. Changes made during reset and while disabled show whether the previous-sample register is reloaded on enable.

// File: rtl/edge_bank_pkg.sv
// Shared types and the detection rule for the edge detector bank.
// Assumes the 2-bit code encoding described in the brief.
package edge_bank_pkg;

    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2,
        EDGE_OFF  = 2'd3
    } edge_code_e;

    // Decide whether the sample pair shows the transition selected by the code.
    function automatic logic edge_seen(input edge_code_e code, input logic now_v, input logic was_v);
        logic res;
        case (code)
            EDGE_RISE: res = now_v & ~was_v;
            EDGE_FALL: res = ~now_v & was_v;
            EDGE_BOTH: res = now_v ^ was_v;
            default:   res = 1'b0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/edge_cfg_regs.sv
// Configuration register file: packed detection-code words, packed mask
// words and a one-bit enable, on a single-cycle write / combinational read port.
// Assumes DATA_W is a multiple of the code width and divides NUM_LINES.
module edge_cfg_regs
    import edge_bank_pkg::*;
#(
    parameter int NUM_LINES = 256,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [ADDR_W-1:0]          cfg_addr,
    input  logic [DATA_W-1:0]          cfg_wdata,
    output logic [DATA_W-1:0]          cfg_rdata,
    output logic [CODE_W*NUM_LINES-1:0] code_flat,
    output logic [NUM_LINES-1:0]       mask_vec,
    output logic                       en
);
    localparam int LINES_PER_CODE_WORD = DATA_W / CODE_W;
    localparam int CODE_WORDS          = NUM_LINES / LINES_PER_CODE_WORD;
    localparam int MASK_WORDS          = NUM_LINES / DATA_W;
    localparam int MASK_BASE           = CODE_WORDS;
    localparam int EN_ADDR             = CODE_WORDS + MASK_WORDS;

    logic [DATA_W-1:0] code_q [CODE_WORDS];
    logic [DATA_W-1:0] mask_q [MASK_WORDS];
    logic              en_q;

    genvar w;
    generate
        for (w = 0; w < CODE_WORDS; w++) begin : g_code
            // Hold one packed detection-code word.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    code_q[w] <= '0;
                else if (cfg_we && cfg_addr == ADDR_W'(w))
                    code_q[w] <= cfg_wdata;
            end
            assign code_flat[w*DATA_W +: DATA_W] = code_q[w];
        end
        for (w = 0; w < MASK_WORDS; w++) begin : g_mask
            // Hold one packed mask word.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mask_q[w] <= '0;
                else if (cfg_we && cfg_addr == ADDR_W'(MASK_BASE + w))
                    mask_q[w] <= cfg_wdata;
            end
            assign mask_vec[w*DATA_W +: DATA_W] = mask_q[w];
        end
    endgenerate

    // Hold the global detection enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (cfg_we && cfg_addr == ADDR_W'(EN_ADDR))
            en_q <= cfg_wdata[0];
    end
    assign en = en_q;

    // Select read data by address; unmapped addresses read zero.
    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < CODE_WORDS; i++)
            if (cfg_addr == ADDR_W'(i)) cfg_rdata = code_q[i];
        for (int i = 0; i < MASK_WORDS; i++)
            if (cfg_addr == ADDR_W'(MASK_BASE + i)) cfg_rdata = mask_q[i];
        if (cfg_addr == ADDR_W'(EN_ADDR)) cfg_rdata = {{(DATA_W-1){1'b0}}, en_q};
    end

    // R2
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADDR_W'(EN_ADDR)) |=> (en == $past(cfg_wdata[0])));

endmodule

// File: rtl/edge_sampler.sv
// Two-stage sampler: current and previous sample of every line.
// While disabled (and in reset) both stages follow the inputs, so the
// first enabled comparison sees no difference.
module edge_sampler #(
    parameter int NUM_LINES = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [NUM_LINES-1:0] line_in,
    output logic [NUM_LINES-1:0] cur_q,
    output logic [NUM_LINES-1:0] prev_q
);
    // Capture inputs and shift the previous sample, or align both when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cur_q  <= line_in;
            prev_q <= line_in;
        end else begin
            cur_q  <= line_in;
            prev_q <= cur_q;
        end
    end

    // R12
    idle_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cur_q == prev_q));

endmodule

// File: rtl/edge_classify.sv
// Per-line combinational classifier: applies each line's detection code
// to its sample pair and removes masked lines.
// Assumes the code of line n sits at bits 2n+1:2n of code_flat.
module edge_classify
    import edge_bank_pkg::*;
#(
    parameter int NUM_LINES = 256
) (
    input  logic [NUM_LINES-1:0]        cur,
    input  logic [NUM_LINES-1:0]        prev,
    input  logic [CODE_W*NUM_LINES-1:0] code_flat,
    input  logic [NUM_LINES-1:0]        mask_vec,
    output logic [NUM_LINES-1:0]        hit
);
    genvar n;
    generate
        for (n = 0; n < NUM_LINES; n++) begin : g_line
            edge_code_e code_n;
            assign code_n = edge_code_e'(code_flat[CODE_W*n +: CODE_W]);
            // One line: detect the selected transition unless masked.
            assign hit[n] = edge_seen(code_n, cur[n], prev[n]) & ~mask_vec[n];
        end
    endgenerate

endmodule

// File: rtl/edge_bank_top.sv
// Top of the programmable edge detector bank. Ties together the register
// file, the sampler and the classifier, and registers the event outputs.
// Assumes a single clock domain; line_in is already synchronous to clk.
module edge_bank_top #(
    parameter int NUM_LINES = 256,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    output logic [NUM_LINES-1:0] evt_vec,
    output logic                 evt_any
);
    localparam int CODE_BITS = edge_bank_pkg::CODE_W * NUM_LINES;

    logic [CODE_BITS-1:0] code_flat;
    logic [NUM_LINES-1:0] mask_vec;
    logic                 en;
    logic [NUM_LINES-1:0] cur_q, prev_q, hit;
    logic [NUM_LINES-1:0] evt_vec_q;
    logic                 evt_any_q;

    edge_cfg_regs #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .code_flat(code_flat), .mask_vec(mask_vec), .en(en)
    );

    edge_sampler #(.NUM_LINES(NUM_LINES)) u_samp (
        .clk(clk), .rst_n(rst_n), .en(en), .line_in(line_in),
        .cur_q(cur_q), .prev_q(prev_q)
    );

    edge_classify #(.NUM_LINES(NUM_LINES)) u_cls (
        .cur(cur_q), .prev(prev_q), .code_flat(code_flat),
        .mask_vec(mask_vec), .hit(hit)
    );

    // Register the gated per-line events and their summary flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_vec_q <= '0;
            evt_any_q <= 1'b0;
        end else begin
            evt_vec_q <= en ? hit : '0;
            evt_any_q <= en & (|hit);
        end
    end

    assign evt_vec = evt_vec_q;
    assign evt_any = evt_any_q;

    // R11
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (evt_vec == '0 && !evt_any));

    // R8
    mask_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_vec & $past(mask_vec)) == '0));

    // R9
    any_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_any == (|evt_vec)));

endmodule

// File: tb/tb_edge_bank_top.sv
`timescale 1ns/1ps
module tb_edge_bank_top;
    localparam int NL = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] line_in = '0;
    logic          cfg_we = 1'b0;
    logic [4:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic [NL-1:0] evt_vec;
    logic          evt_any;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    edge_bank_top dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .evt_vec(evt_vec), .evt_any(evt_any)
    );

    typedef struct packed {
        logic [7:0] idx;
        logic [1:0] code;
        logic       msk;
        logic       from_lvl;
        logic       to_lvl;
        logic       hit;
    } vec_t;

    // line, code, mask, from, to, expected event
    localparam vec_t VEC [16] = '{
        '{8'd0,   2'd0, 1'b0, 1'b0, 1'b1, 1'b1},  // R3 rise
        '{8'd0,   2'd0, 1'b0, 1'b1, 1'b0, 1'b0},  // R3 fall ignored
        '{8'd17,  2'd1, 1'b0, 1'b1, 1'b0, 1'b1},  // R4 fall
        '{8'd17,  2'd1, 1'b0, 1'b0, 1'b1, 1'b0},  // R4 rise ignored
        '{8'd35,  2'd2, 1'b0, 1'b0, 1'b1, 1'b1},  // R5
        '{8'd35,  2'd2, 1'b0, 1'b1, 1'b0, 1'b1},  // R5
        '{8'd50,  2'd3, 1'b0, 1'b0, 1'b1, 1'b0},  // R6
        '{8'd50,  2'd3, 1'b0, 1'b1, 1'b0, 1'b0},  // R6
        '{8'd255, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1},  // R7 last line
        '{8'd240, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1},  // R7 last word start
        '{8'd15,  2'd1, 1'b0, 1'b1, 1'b0, 1'b1},  // R7 top field of word 0
        '{8'd16,  2'd0, 1'b0, 1'b0, 1'b1, 1'b1},  // R7 first field of word 1
        '{8'd31,  2'd2, 1'b1, 1'b0, 1'b1, 1'b0},  // R8 masked
        '{8'd32,  2'd0, 1'b1, 1'b0, 1'b1, 1'b0},  // R8 masked, mask word 1
        '{8'd100, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 no change
        '{8'd200, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0}   // R4 no change
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        cfg_addr = 5'(a);
        #1;
        d = cfg_rdata;
    endtask

    task automatic chk(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.msk) return "R8";
        if (v.idx == 8'd15 || v.idx == 8'd16 || v.idx == 8'd240 || v.idx == 8'd255) return "R7";
        case (v.code)
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rv;
        vec_t v;
        logic [NL-1:0] exp;

        // R1 / R12: inputs busy during reset.
        line_in = {8{32'h5A5A_C3C3}};
        repeat (3) tick();
        line_in = ~line_in;
        tick();
        rst_n = 1'b1;
        tick();
        chk("R1", evt_vec, '0);
        chk("R1", NL'(evt_any), '0);
        rd(0, rv);  chk("R1", NL'(rv), '0);
        rd(16, rv); chk("R1", NL'(rv), '0);
        rd(24, rv); chk("R1", NL'(rv), '0);

        // R2 register map.
        wr(5, 32'hA5A5_1234);  rd(5, rv);  chk("R2", NL'(rv), NL'(32'hA5A5_1234));
        wr(20, 32'hDEAD_BEEF); rd(20, rv); chk("R2", NL'(rv), NL'(32'hDEAD_BEEF));
        wr(30, 32'hFFFF_FFFF); rd(30, rv); chk("R2", NL'(rv), '0);
        rd(25, rv); chk("R2", NL'(rv), '0);
        wr(5, 0); wr(20, 0);

        // R12: enable after reset-time changes, inputs steady; nothing reported.
        wr(24, 32'hFFFF_FFFF);
        rd(24, rv); chk("R2", NL'(rv), NL'(1));
        repeat (3) tick();
        chk("R12", evt_vec, '0);

        // Table walk.
        for (int i = 0; i < 16; i++) begin
            v = VEC[i];
            wr(int'(v.idx) / 16, 32'(v.code) << (2 * (int'(v.idx) % 16)));
            wr(16 + int'(v.idx) / 32, 32'(v.msk) << (int'(v.idx) % 32));
            line_in = '0;
            line_in[v.idx] = v.from_lvl;
            repeat (3) tick();
            line_in[v.idx] = v.to_lvl;
            tick();
            tick();
            exp = v.hit ? (NL'(1) << v.idx) : '0;
            chk(tag_of(v), evt_vec, exp);
            chk(tag_of(v), NL'(evt_any), NL'(v.hit));
        end

        // Clear table configuration.
        for (int w = 0; w < 24; w++) wr(w, 0);

        // R10: exact latency and one-cycle width.
        line_in = '0;
        repeat (3) tick();
        line_in[3] = 1'b1;
        tick();
        chk("R10", evt_vec, '0);
        tick();
        chk("R10", evt_vec, NL'(8));
        tick();
        chk("R10", evt_vec, '0);

        // R5 / R9: several lines at once, all with both-edge codes.
        wr(0, 32'hAAAA_AAAA);
        line_in = '0;
        repeat (3) tick();
        line_in[15:0] = 16'h0F0F;
        tick(); tick();
        chk("R5", evt_vec, NL'(16'h0F0F));
        chk("R9", NL'(evt_any), NL'(1));

        // R8: partial mask.
        wr(16, 32'h0000_000F);
        line_in[15:0] = 16'h0000;
        tick(); tick();
        chk("R8", evt_vec, NL'(16'h0F00));
        chk("R9", NL'(evt_any), NL'(1));

        // R8 / R9: every changing line masked.
        wr(16, 32'h0000_FFFF);
        line_in[15:0] = 16'hFFFF;
        tick(); tick();
        chk("R8", evt_vec, '0);
        chk("R9", NL'(evt_any), '0);
        wr(16, 0);

        // R11: disabled, changes ignored.
        wr(24, 0);
        line_in[0] = 1'b0;
        tick(); tick();
        chk("R11", evt_vec, '0);
        chk("R11", NL'(evt_any), '0);

        // R12: change while disabled, then enable.
        line_in[1] = 1'b0;
        tick();
        wr(24, 1);
        repeat (3) tick();
        chk("R12", evt_vec, '0);
        line_in[1] = 1'b1;
        tick(); tick();
        chk("R12", evt_vec, NL'(2));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule